// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines and turns them into two processor interrupt outputs. A single dedicated pin feeds the fast interrupt output and nothing else can drive it. All other sources compete for the normal interrupt output. Each normal source carries a mask bit, a three-bit priority and a sensitivity mode. The controller picks the pending unmasked source with the highest priority. When the processor reads the vector register, the controller returns the handler address stored for that source.

Reading the vector acknowledges the source. That read clears the source's edge latch and records its priority on a nesting stack. While a handler is running, only sources of strictly higher priority can raise the normal interrupt again. Writing the end-of-interrupt register closes the newest level and lets lower levels compete once more. The top few source numbers are external pins and accept four sensitivities. The remaining sources are on-chip and choose only between level and edge.

Software reaches the controller through a simple single-cycle read/write bus with word addresses. Read data is registered and appears one clock after the read strobe. Source lines are assumed to be synchronous to the clock already.

Top module: `pic_ctrl`

## Requirements
- R1: After reset both interrupt outputs are low, every source is masked, the pending word reads zero and the read data bus is zero.
- R2: `fiq_o` equals `fiq_pin_i` delayed by one clock, whatever the normal sources do.
- R3: A source whose enable bit (bit 5 of its config word at address 0x20+n) is zero never raises `irq_o`, even while it is pending.
- R4: Config bits [2:0] hold the priority. Among eligible sources the highest priority wins, and a read of address 0x00 returns that source's vector (address 0x40+n).
- R5: When eligible sources share the top priority, the lowest source number wins.
- R6: On-chip sources (below NUM_SRC-NUM_EXT) use only mode bit 3 (0 = level high, 1 = rising edge). Mode bit 4 is ignored, so a "low" setting still behaves as active high.
- R7: External sources (the top NUM_EXT numbers) decode config bits [4:3] as 0 = high level, 1 = rising edge, 2 = low level, 3 = falling edge.
- R8: An edge-mode source stays pending after its pulse ends until a vector read acknowledges it. That read clears its latch, and the pending word at address 0x02 then shows the bit clear.
- R9: A vector read that finds a winner pushes its priority. Afterwards only sources of strictly higher priority raise `irq_o`.
- R10: A write to address 0x01 pops one nesting level, which makes the lower-priority pending sources eligible again. A pop on an empty stack has no effect.
- R11: A vector read with no eligible source returns the spurious vector register (address 0x03) and pushes nothing.
- R12: The nesting stack holds eight levels, enough for one active handler at every priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Normal interrupt request lines; the top NUM_EXT are external pins |
| fiq_pin_i | input | 1 | Dedicated fast interrupt pin |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address: [6:5] region (0 control, 1 config, 2 vector), [4:0] index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The priority resolver is exercised with several patterns. A single source tests masking. Two sources of different priority test the ordering. Two equal-priority sources separate a lowest-index winner from a highest-index one. Nesting is tried in three ways: with a higher-priority arrival during a handler, with an equal-priority arrival, and with a full ladder of all eight levels, so that a stack that accepts equal levels or drops a level on pop stands out. Each sensitivity mode is driven with both its active and its inactive transition. This shows whether polarity is honoured on external pins and ignored on internal ones, and whether edge latches survive the end of the pulse.

// File: rtl/pic_pkg.sv
// Shared types and register map constants for the nested priority interrupt
// controller. Assumes word addressing with a 2-bit region and a 5-bit index.
package pic_pkg;
    localparam int PRIO_W  = 3;
    localparam int NUM_LVL = 1 << PRIO_W;

    // Sensitivity code: bit0 selects edge, bit1 selects active-low/falling.
    typedef enum logic [1:0] {
        SENS_HIGH = 2'd0,
        SENS_RISE = 2'd1,
        SENS_LOW  = 2'd2,
        SENS_FALL = 2'd3
    } sens_e;

    // Per-source configuration word, bit 5 enable, [4:3] mode, [2:0] priority.
    typedef struct packed {
        logic                en;
        sens_e               mode;
        logic [PRIO_W-1:0]   prio;
    } src_cfg_t;

    localparam logic [1:0] RGN_CTL = 2'd0;
    localparam logic [1:0] RGN_CFG = 2'd1;
    localparam logic [1:0] RGN_VEC = 2'd2;

    localparam logic [4:0] CTL_IVR  = 5'd0;
    localparam logic [4:0] CTL_EOI  = 5'd1;
    localparam logic [4:0] CTL_PEND = 5'd2;
    localparam logic [4:0] CTL_SPUR = 5'd3;
endpackage

// File: rtl/pic_detect.sv
// Per-source request conditioning. Level sources follow their (possibly
// inverted) line one clock later; edge sources latch a detected transition
// until the acknowledge clear arrives. Only the top NUM_EXT sources honour the
// polarity bit. Assumes src_i is already synchronous to clk.
module pic_detect #(
    parameter int NUM_SRC = 32,
    parameter int NUM_EXT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [1:0]         mode_i [NUM_SRC],
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    localparam int FIRST_EXT = NUM_SRC - NUM_EXT;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic IS_EXT = (g >= FIRST_EXT);
        logic prev_q;
        logic pend_q;
        logic is_edge;
        logic inv;
        logic hit;

        assign is_edge = mode_i[g][0];
        assign inv     = mode_i[g][1] & IS_EXT;
        assign hit     = inv ? (prev_q & ~src_i[g]) : (src_i[g] & ~prev_q);

        // Track the previous line value and update the pending state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= src_i[g];
                if (is_edge)
                    pend_q <= (pend_q & ~clr_i[g]) | hit;
                else
                    pend_q <= src_i[g] ^ inv;
            end
        end

        assign pend_o[g] = pend_q;

        // An edge latch only drops through an acknowledge or a mode change.
        assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && is_edge && !clr_i[g]) |=> (pend_q || !mode_i[g][0]));
    end
endmodule

// File: rtl/pic_arbiter.sv
// Combinational winner selection. A source is eligible when pending, enabled
// and, while a handler is active, strictly above the current nesting level.
// Highest priority wins; equal priorities go to the lowest index.
module pic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
    input  logic               nest_active_i,
    input  logic [PRIO_W-1:0]  nest_lvl_i,
    output logic               win_valid_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic [PRIO_W-1:0]  win_prio_o
);
    // Linear scan; strict comparison keeps the earliest index on ties.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && en_i[i] &&
                (!nest_active_i || (prio_i[i] > nest_lvl_i)) &&
                (!win_valid_o || (prio_i[i] > win_prio_o))) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_i[i];
            end
        end
    end

    assert_win_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (en_i[win_idx_o] && pend_i[win_idx_o]));

    assert_preempt_higher_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && nest_active_i) |-> (win_prio_o > nest_lvl_i));
endmodule

// File: rtl/pic_nest.sv
// Nesting stack of acknowledged priority levels. Push on acknowledge, pop on
// end-of-interrupt; a pop on an empty stack is dropped. Assumes pushes are
// strictly increasing, which bounds occupancy at DEPTH.
module pic_nest #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_lvl_i,
    input  logic              pop_i,
    output logic              active_o,
    output logic [PRIO_W-1:0] lvl_o
);
    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic [SP_W-1:0]   sp_q;

    // Stack pointer and entry updates; push takes precedence over pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push_i && (sp_q < SP_W'(DEPTH))) begin
            stk_q[IDX_W'(sp_q)] <= push_lvl_i;
            sp_q <= sp_q + 1'b1;
        end else if (pop_i && (sp_q != '0)) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    assign active_o = (sp_q != '0);
    assign lvl_o    = active_o ? stk_q[IDX_W'(sp_q - 1'b1)] : '0;

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp_q < SP_W'(DEPTH)));

    assert_push_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && active_o) |-> (push_lvl_i > lvl_o));

    assert_pop_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && active_o) |=> (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/pic_ctrl.sv
// Top of the nested priority interrupt controller: register file, bus decode,
// acknowledge and end-of-interrupt strobes, fast interrupt path. Assumes one
// bus access per cycle and NUM_SRC <= 32, NUM_SRC <= DATA_W.
module pic_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int NUM_EXT = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               fiq_pin_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    import pic_pkg::*;

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int FLD_W  = ADDR_W - 2;
    localparam int CFG_W  = $bits(src_cfg_t);

    src_cfg_t             cfg_q  [NUM_SRC];
    logic [DATA_W-1:0]    vec_q  [NUM_SRC];
    logic [DATA_W-1:0]    spur_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 fiq_q;

    logic [1:0]           rgn;
    logic [FLD_W-1:0]     fld;
    logic [IDX_W-1:0]     sidx;
    logic                 in_range;
    logic                 wr_en, rd_en;
    logic                 ivr_rd, eoi_wr, ack;

    logic [1:0]           mode   [NUM_SRC];
    logic [PRIO_W-1:0]    prio   [NUM_SRC];
    logic [NUM_SRC-1:0]   en;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   clr;

    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    logic [PRIO_W-1:0]    win_prio;
    logic                 nest_active;
    logic [PRIO_W-1:0]    nest_lvl;
    logic [DATA_W-1:0]    rd_val;

    // Bus decode into region, field and source index.
    assign rgn      = bus_addr_i[ADDR_W-1 -: 2];
    assign fld      = bus_addr_i[FLD_W-1:0];
    assign sidx     = IDX_W'(fld);
    assign in_range = (32'(fld) < NUM_SRC);
    assign wr_en    = bus_en_i & bus_we_i;
    assign rd_en    = bus_en_i & ~bus_we_i;
    assign ivr_rd   = rd_en  && (rgn == RGN_CTL) && (fld == FLD_W'(CTL_IVR));
    assign eoi_wr   = wr_en  && (rgn == RGN_CTL) && (fld == FLD_W'(CTL_EOI));
    assign ack      = ivr_rd && win_valid;

    // Split the config words into per-field arrays for the sub-blocks.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            mode[i] = cfg_q[i].mode;
            prio[i] = cfg_q[i].prio;
            en[i]   = cfg_q[i].en;
            clr[i]  = ack && (win_idx == IDX_W'(i));
        end
    end

    // Register writes from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_q[i] <= '0;
                vec_q[i] <= '0;
            end
            spur_q <= '0;
        end else if (wr_en) begin
            unique case (rgn)
                RGN_CFG: if (in_range) cfg_q[sidx] <= src_cfg_t'(bus_wdata_i[CFG_W-1:0]);
                RGN_VEC: if (in_range) vec_q[sidx] <= bus_wdata_i;
                RGN_CTL: if (fld == FLD_W'(CTL_SPUR)) spur_q <= bus_wdata_i;
                default: ;
            endcase
        end
    end

    // Read data selection for the current access.
    always_comb begin
        rd_val = '0;
        unique case (rgn)
            RGN_CTL: begin
                if (fld == FLD_W'(CTL_IVR))
                    rd_val = win_valid ? vec_q[win_idx] : spur_q;
                else if (fld == FLD_W'(CTL_PEND))
                    rd_val[NUM_SRC-1:0] = pend;
                else if (fld == FLD_W'(CTL_SPUR))
                    rd_val = spur_q;
            end
            RGN_CFG: if (in_range) rd_val[CFG_W-1:0] = cfg_q[sidx];
            RGN_VEC: if (in_range) rd_val = vec_q[sidx];
            default: ;
        endcase
    end

    // Register read data and the fast interrupt path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            fiq_q   <= 1'b0;
        end else begin
            fiq_q <= fiq_pin_i;
            if (rd_en) rdata_q <= rd_val;
        end
    end

    pic_detect #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .mode_i (mode),
        .clr_i  (clr),
        .pend_o (pend)
    );

    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_i        (pend),
        .en_i          (en),
        .prio_i        (prio),
        .nest_active_i (nest_active),
        .nest_lvl_i    (nest_lvl),
        .win_valid_o   (win_valid),
        .win_idx_o     (win_idx),
        .win_prio_o    (win_prio)
    );

    pic_nest #(.DEPTH(NUM_LVL), .PRIO_W(PRIO_W)) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack),
        .push_lvl_i (win_prio),
        .pop_i      (eoi_wr),
        .active_o   (nest_active),
        .lvl_o      (nest_lvl)
    );

    assign bus_rdata_o = rdata_q;
    assign irq_o       = win_valid;
    assign fiq_o       = fiq_q;

    assert_fiq_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(fiq_pin_i)));

    assert_single_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          fiq_pin = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq, fiq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pic_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .fiq_pin_i(fiq_pin),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] vec_of(input int n);
        return 32'h1000 + 32'(n) * 32'h10;
    endfunction
    localparam logic [31:0] SPUR = 32'h0BAD;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cfg(input int n, input int pr, input int md, input bit e);
        wr(7'h20 + 7'(n), {26'b0, e, 2'(md), 3'(pr)});
    endtask

    task automatic eoi();
        wr(7'h01, 32'h0);
    endtask

    task automatic set_src(input int n, input bit v);
        @(negedge clk);
        src[n] = v;
    endtask

    // R1: outputs and pending word after reset
    task automatic t_reset();
        logic [31:0] d;
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        check(fiq == 1'b0, "R1 fiq", 32'(fiq), 0);
        check(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 0);
        rd(7'h02, d);
        check(d == 32'h0, "R1 pend", d, 0);
        rd(7'h20, d);
        check(d == 32'h0, "R1 cfg masked", d, 0);
    endtask

    // R2: fast pin path, independent of normal sources
    task automatic t_fiq();
        @(negedge clk); fiq_pin = 1'b1;
        check(fiq == 1'b0, "R2 not yet", 32'(fiq), 0);
        tick(1);
        check(fiq == 1'b1, "R2 rise", 32'(fiq), 1);
        check(irq == 1'b0, "R2 irq untouched", 32'(irq), 0);
        @(negedge clk); fiq_pin = 1'b0;
        tick(1);
        check(fiq == 1'b0, "R2 fall", 32'(fiq), 0);
    endtask

    // R3: masked source stays silent until enabled
    task automatic t_mask();
        logic [31:0] d;
        cfg(2, 4, 0, 1'b0);
        set_src(2, 1'b1);
        tick(2);
        check(irq == 1'b0, "R3 masked", 32'(irq), 0);
        rd(7'h02, d);
        check(d[2] == 1'b1, "R3 pending while masked", d, 32'h4);
        cfg(2, 4, 0, 1'b1);
        check(irq == 1'b1, "R3 unmasked", 32'(irq), 1);
        set_src(2, 1'b0);
        cfg(2, 0, 0, 1'b0);
        check(irq == 1'b0, "R3 cleanup", 32'(irq), 0);
    endtask

    // R4: higher priority wins regardless of index
    task automatic t_prio();
        logic [31:0] d;
        cfg(4, 3, 0, 1'b1);
        cfg(9, 6, 0, 1'b1);
        set_src(4, 1'b1); set_src(9, 1'b1);
        tick(1);
        rd(7'h00, d);
        check(d == vec_of(9), "R4 vector", d, vec_of(9));
        eoi();
        set_src(9, 1'b0);
        tick(1);
        rd(7'h00, d);
        check(d == vec_of(4), "R4 next winner", d, vec_of(4));
        eoi();
        set_src(4, 1'b0);
        cfg(4, 0, 0, 1'b0); cfg(9, 0, 0, 1'b0);
    endtask

    // R5: equal priority goes to the lowest source number
    task automatic t_tie();
        logic [31:0] d;
        cfg(7, 4, 0, 1'b1);
        cfg(5, 4, 0, 1'b1);
        set_src(7, 1'b1); set_src(5, 1'b1);
        tick(1);
        rd(7'h00, d);
        check(d == vec_of(5), "R5 tie", d, vec_of(5));
        eoi();
        set_src(7, 1'b0); set_src(5, 1'b0);
        cfg(7, 0, 0, 1'b0); cfg(5, 0, 0, 1'b0);
        tick(1);
        check(irq == 1'b0, "R5 cleanup", 32'(irq), 0);
    endtask

    // R6: internal source ignores the polarity bit
    task automatic t_int_mode();
        cfg(1, 2, 2, 1'b1);
        tick(1);
        check(irq == 1'b0, "R6 low line inactive", 32'(irq), 0);
        set_src(1, 1'b1);
        tick(1);
        check(irq == 1'b1, "R6 high line active", 32'(irq), 1);
        set_src(1, 1'b0);
        tick(1);
        check(irq == 1'b0, "R6 follows level", 32'(irq), 0);
        cfg(1, 0, 0, 1'b0);
    endtask

    // R7: external pins in all four sensitivities
    task automatic t_ext_modes();
        logic [31:0] d;
        cfg(29, 3, 3, 1'b1);
        set_src(29, 1'b1);
        tick(2);
        check(irq == 1'b0, "R7 falling ignores rise", 32'(irq), 0);
        set_src(29, 1'b0);
        tick(3);
        check(irq == 1'b1, "R7 falling latched", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(29), "R7 falling vector", d, vec_of(29));
        eoi();
        check(irq == 1'b0, "R7 falling cleared", 32'(irq), 0);
        cfg(29, 0, 0, 1'b0);

        set_src(30, 1'b1);
        cfg(30, 2, 2, 1'b1);
        tick(1);
        check(irq == 1'b0, "R7 low-level idle", 32'(irq), 0);
        set_src(30, 1'b0);
        tick(1);
        check(irq == 1'b1, "R7 low-level active", 32'(irq), 1);
        cfg(30, 2, 0, 1'b1);
        tick(1);
        check(irq == 1'b0, "R7 high-level idle", 32'(irq), 0);
        set_src(30, 1'b1);
        tick(1);
        check(irq == 1'b1, "R7 high-level active", 32'(irq), 1);
        set_src(30, 1'b0);
        cfg(30, 0, 0, 1'b0);

        cfg(31, 1, 1, 1'b1);
        set_src(31, 1'b1);
        set_src(31, 1'b0);
        tick(2);
        check(irq == 1'b1, "R7 rising latched", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(31), "R7 rising vector", d, vec_of(31));
        eoi();
        cfg(31, 0, 0, 1'b0);
        check(irq == 1'b0, "R7 cleanup", 32'(irq), 0);
    endtask

    // R8: edge latch holds until the vector read
    task automatic t_edge_hold();
        logic [31:0] d;
        cfg(3, 5, 1, 1'b1);
        set_src(3, 1'b1);
        set_src(3, 1'b0);
        tick(5);
        check(irq == 1'b1, "R8 held after pulse", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(3), "R8 vector", d, vec_of(3));
        rd(7'h02, d);
        check(d[3] == 1'b0, "R8 latch cleared", d, 32'h0);
        eoi();
        check(irq == 1'b0, "R8 no refire", 32'(irq), 0);
        cfg(3, 0, 0, 1'b0);
    endtask

    // R9 and R10: preemption only by strictly higher levels, pop restores
    task automatic t_preempt();
        logic [31:0] d;
        cfg(10, 2, 0, 1'b1); cfg(11, 2, 0, 1'b1); cfg(12, 5, 0, 1'b1);
        set_src(10, 1'b1);
        tick(1);
        rd(7'h00, d);
        check(d == vec_of(10), "R9 first ack", d, vec_of(10));
        check(irq == 1'b0, "R9 same source blocked", 32'(irq), 0);
        set_src(11, 1'b1);
        tick(1);
        check(irq == 1'b0, "R9 equal level blocked", 32'(irq), 0);
        set_src(12, 1'b1);
        tick(1);
        check(irq == 1'b1, "R9 higher preempts", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(12), "R9 preempt vector", d, vec_of(12));
        set_src(12, 1'b0);
        eoi();
        check(irq == 1'b0, "R10 back to level 2", 32'(irq), 0);
        eoi();
        check(irq == 1'b1, "R10 stack empty", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(10), "R10 reevaluated", d, vec_of(10));
        eoi();
        set_src(10, 1'b0); set_src(11, 1'b0);
        cfg(10, 0, 0, 1'b0); cfg(11, 0, 0, 1'b0); cfg(12, 0, 0, 1'b0);
        eoi();
        check(irq == 1'b0, "R10 empty pop harmless", 32'(irq), 0);
    endtask

    // R11: spurious read returns the spurious vector and pushes nothing
    task automatic t_spurious();
        logic [31:0] d;
        rd(7'h00, d);
        check(d == SPUR, "R11 spurious vector", d, SPUR);
        cfg(0, 0, 0, 1'b1);
        set_src(0, 1'b1);
        tick(1);
        check(irq == 1'b1, "R11 no level pushed", 32'(irq), 1);
        set_src(0, 1'b0);
        cfg(0, 0, 0, 1'b0);
    endtask

    // R12: one active handler at each of the eight levels
    task automatic t_depth();
        logic [31:0] d;
        for (int k = 0; k < 8; k++) begin
            cfg(13 + k, k, 0, 1'b1);
            set_src(13 + k, 1'b1);
            tick(1);
            rd(7'h00, d);
            check(d == vec_of(13 + k), "R12 ladder ack", d, vec_of(13 + k));
        end
        check(irq == 1'b0, "R12 all levels busy", 32'(irq), 0);
        eoi();
        check(irq == 1'b1, "R12 top level freed", 32'(irq), 1);
        rd(7'h00, d);
        check(d == vec_of(20), "R12 reack top", d, vec_of(20));
        for (int k = 0; k < 8; k++) eoi();
        rd(7'h00, d);
        check(d == vec_of(20), "R12 fully unwound", d, vec_of(20));
        for (int k = 0; k < 8; k++) begin
            src[13 + k] = 1'b0;
            cfg(13 + k, 0, 0, 1'b0);
        end
        eoi();
        check(irq == 1'b0, "R12 cleanup", 32'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        t_reset();
        for (int n = 0; n < NS; n++) wr(7'h40 + 7'(n), vec_of(n));
        wr(7'h03, SPUR);
        t_fiq();
        t_mask();
        t_prio();
        t_tie();
        t_int_mode();
        t_ext_modes();
        t_edge_hold();
        t_preempt();
        t_spurious();
        t_depth();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule